// File: doc/BRIEF.md
# Line Brownout Detector with Timed Hysteresis

This block decides when the rectified mains has sagged long enough to put a power-factor stage into standby, and when it has recovered long enough to resume switching. Once per half-line cycle an upstream stage delivers one peak code of the rectified line, in volts at one volt per LSB. The block keeps a filtered copy of that peak. The copy follows a higher peak at once, but it can drop by no more than a fixed step for each new peak. Because of this, a sudden dip lowers it only gradually.

Two thresholds give hysteresis. While the stage is running, a filtered peak strictly below the lower threshold starts a dwell timer. If the condition holds without a break for the full dwell time, brownout is declared and the gate enable drops. While in standby, a filtered peak strictly above the upper threshold starts a second dwell timer of the same length. When that timer expires, the stage returns to normal running. Either timer goes back to zero as soon as its condition breaks. The dwell time is counted in millisecond ticks from an input strobe, after an optional parameterised prescaler. The upper threshold parameter must be larger than the lower one.

Top module: `bo_brownout_detector`

## Requirements
- R1: After reset the filtered peak is 0, brownout is 0 and gate enable is 1.
- R2: One clock after a peak strobe, a code that is greater than or equal to the filtered peak replaces the filtered peak immediately.
- R3: When a strobed code is below the filtered peak, the new filtered peak is the larger of the code and (filtered peak minus STEP), with STEP = 5 by default.
- R4: Without a peak strobe the filtered peak does not change.
- R5: In normal running, the low condition is a filtered peak strictly below LOWER (default 95). Brownout is set one clock after the DWELL-th tick (default 56, with prescale 1) that is counted while the low condition holds. A filtered peak equal to LOWER does not count as low.
- R6: When the low condition breaks before expiry, the entry timer returns to zero, and a later low period needs a full DWELL ticks again.
- R7: In standby, the high condition is a filtered peak strictly above UPPER (default 110). Brownout is cleared one clock after the DWELL-th tick counted while the high condition holds. A filtered peak equal to UPPER does not count as high.
- R8: When the high condition breaks before expiry, the exit timer returns to zero, and a later high period needs a full DWELL ticks again.
- R9: Gate enable is always the inverse of brownout.
- R10: The timers advance only on ms_tick strobes. A low filtered peak held for any number of clocks without ticks never declares brownout. Starting from a filtered peak of 128 with zero-volt peaks, one every 8 ticks, brownout is declared 56 ticks after the seventh peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-clock millisecond strobe |
| peak_valid | input | 1 | Strobe: peak_code holds a new half-cycle peak |
| peak_code | input | PEAK_W | Peak of the rectified line, 1 V per LSB |
| peak_filt | output | PEAK_W | Slew-limited filtered peak |
| brownout | output | 1 | 1 while in standby due to brownout |
| gate_en | output | 1 | 1 while gate switching is permitted |

## Verification
The bound checker checks the filter's rules on every clock: an immediate rise to a higher code, a fall of no more than STEP per strobe, and holding still between strobes. It also keeps its own count of the ticks spent below LOWER and above UPPER. Each edge of brownout must follow a complete qualifying run. Timer clearing after a broken condition, the exact tick on which each transition happens, the strict threshold comparisons and the worst-case entry time from a 128 V line are shown only by the bench's scenarios.

// File: rtl/bo_pkg.sv
package bo_pkg;

    localparam int PEAK_MAX_W = 16;

    typedef logic [PEAK_MAX_W-1:0] peak_word_t;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_STANDBY = 1'b1
    } bo_state_e;

    // Index of each dwell timer in the timer array
    localparam int TMR_ENTRY = 0;
    localparam int TMR_EXIT  = 1;
    localparam int TMR_COUNT = 2;

    // Rises follow the new peak at once; falls are limited to `step`.
    function automatic peak_word_t slew_next(peak_word_t cur, peak_word_t pk,
                                             peak_word_t step);
        if (pk >= cur)
            return pk;
        if ((cur - pk) > step)
            return cur - step;
        return pk;
    endfunction

endpackage

// File: rtl/bo_peak_filter.sv
module bo_peak_filter
    import bo_pkg::*;
#(
    parameter int PEAK_W = 10,
    parameter int STEP   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [PEAK_W-1:0] code,
    output logic [PEAK_W-1:0] filt
);

    peak_word_t cur_w;
    peak_word_t code_w;
    peak_word_t next_w;

    always_comb begin
        cur_w               = '0;
        code_w              = '0;
        cur_w[PEAK_W-1:0]   = filt;
        code_w[PEAK_W-1:0]  = code;
        next_w              = slew_next(cur_w, code_w, peak_word_t'(STEP));
    end

    always_ff @(posedge clk) begin
        if (rst)
            filt <= '0;
        else if (strobe)
            filt <= next_w[PEAK_W-1:0];
    end

endmodule

// File: rtl/bo_dwell_timer.sv
module bo_dwell_timer #(
    parameter int DWELL = 56
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tick,
    output logic expired
);

    localparam int CW = $clog2(DWELL + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DWELL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else if (tick && (cnt != LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = arm && (cnt == LIMIT);

endmodule

// File: rtl/bo_brownout_detector.sv
module bo_brownout_detector
    import bo_pkg::*;
#(
    parameter int PEAK_W   = 10,
    parameter int LOWER    = 95,
    parameter int UPPER    = 110,
    parameter int STEP     = 5,
    parameter int DWELL    = 56,
    parameter int TICK_DIV = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              peak_valid,
    input  logic [PEAK_W-1:0] peak_code,
    output logic [PEAK_W-1:0] peak_filt,
    output logic              brownout,
    output logic              gate_en
);

    localparam logic [PEAK_W-1:0] LO_TH = PEAK_W'(LOWER);
    localparam logic [PEAK_W-1:0] HI_TH = PEAK_W'(UPPER);

    bo_state_e             st_q;
    bo_state_e             st_d;
    logic                  tick_eff;
    logic                  line_low;
    logic                  line_high;
    logic [TMR_COUNT-1:0]  arm;
    logic [TMR_COUNT-1:0]  expired;

    // Prescaler on the millisecond strobe
    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            assign tick_eff = ms_tick;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] dcnt;
            always_ff @(posedge clk) begin
                if (rst)
                    dcnt <= '0;
                else if (ms_tick)
                    dcnt <= (dcnt == DLAST) ? '0 : dcnt + 1'b1;
            end
            assign tick_eff = ms_tick && (dcnt == DLAST);
        end
    endgenerate

    bo_peak_filter #(
        .PEAK_W (PEAK_W),
        .STEP   (STEP)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .strobe (peak_valid),
        .code   (peak_code),
        .filt   (peak_filt)
    );

    assign line_low  = peak_filt < LO_TH;
    assign line_high = peak_filt > HI_TH;

    assign arm[TMR_ENTRY] = (st_q == ST_RUN)     && line_low;
    assign arm[TMR_EXIT]  = (st_q == ST_STANDBY) && line_high;

    generate
        for (genvar i = 0; i < TMR_COUNT; i++) begin : g_tmr
            bo_dwell_timer #(
                .DWELL (DWELL)
            ) u_tmr (
                .clk     (clk),
                .rst     (rst),
                .arm     (arm[i]),
                .tick    (tick_eff),
                .expired (expired[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:     if (expired[TMR_ENTRY]) st_d = ST_STANDBY;
            ST_STANDBY: if (expired[TMR_EXIT])  st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    assign brownout = (st_q == ST_STANDBY);
    assign gate_en  = (st_q == ST_RUN);

endmodule

// File: rtl/bo_brownout_checker.sv
module bo_brownout_checker #(
    parameter int PEAK_W   = 10,
    parameter int LOWER    = 95,
    parameter int UPPER    = 110,
    parameter int STEP     = 5,
    parameter int DWELL    = 56,
    parameter int TICK_DIV = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              ms_tick,
    input logic              peak_valid,
    input logic [PEAK_W-1:0] peak_code,
    input logic [PEAK_W-1:0] peak_filt,
    input logic              brownout
);

    localparam int MIN_RAW = (DWELL - 1) * TICK_DIV + 1;

    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;
    logic        is_low;
    logic        is_high;

    assign is_low  = int'(peak_filt) < LOWER;
    assign is_high = int'(peak_filt) > UPPER;

    always_ff @(posedge clk) begin
        if (rst || brownout || !is_low)
            lo_cnt <= '0;
        else if (ms_tick && lo_cnt != 16'hFFFF)
            lo_cnt <= lo_cnt + 16'd1;
    end

    always_ff @(posedge clk) begin
        if (rst || !brownout || !is_high)
            hi_cnt <= '0;
        else if (ms_tick && hi_cnt != 16'hFFFF)
            hi_cnt <= hi_cnt + 16'd1;
    end

    a_r2_rise_follows: assert property (@(posedge clk) disable iff (rst)
        ($past(peak_valid) && ($past(peak_code) >= $past(peak_filt)))
        |-> (peak_filt == $past(peak_code)));

    a_r3_fall_limited: assert property (@(posedge clk) disable iff (rst)
        (int'(peak_filt) + STEP >= int'($past(peak_filt))));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(peak_valid) |-> $stable(peak_filt));

    a_r5_entry_dwell: assert property (@(posedge clk) disable iff (rst)
        $rose(brownout) |-> ($past(is_low) && (int'($past(lo_cnt)) >= MIN_RAW)));

    a_r7_exit_dwell: assert property (@(posedge clk) disable iff (rst)
        $fell(brownout) |-> ($past(is_high) && (int'($past(hi_cnt)) >= MIN_RAW)));

endmodule

bind bo_brownout_detector bo_brownout_checker #(
    .PEAK_W   (PEAK_W),
    .LOWER    (LOWER),
    .UPPER    (UPPER),
    .STEP     (STEP),
    .DWELL    (DWELL),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .peak_valid (peak_valid),
    .peak_code  (peak_code),
    .peak_filt  (peak_filt),
    .brownout   (brownout)
);

// File: tb/bo_brownout_detector_test.sv
module bo_brownout_detector_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       peak_valid = 1'b0;
    logic [9:0] peak_code = '0;
    logic [9:0] peak_filt;
    logic       brownout;
    logic       gate_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bo_brownout_detector uut (
        .clk        (clk),
        .rst        (rst),
        .ms_tick    (ms_tick),
        .peak_valid (peak_valid),
        .peak_code  (peak_code),
        .peak_filt  (peak_filt),
        .brownout   (brownout),
        .gate_en    (gate_en)
    );

    // {strobed code, expected filtered peak}, starting from reset value 0
    localparam logic [19:0] VEC [0:9] = '{
        {10'd200, 10'd200}, {10'd150, 10'd195}, {10'd198, 10'd198},
        {10'd190, 10'd193}, {10'd192, 10'd192}, {10'd300, 10'd300},
        {10'd0,   10'd295}, {10'd0,   10'd290}, {10'd296, 10'd296},
        {10'd296, 10'd296}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic pulse_peak(input int v);
        @(negedge clk);
        peak_code  = 10'(v);
        peak_valid = 1'b1;
        @(negedge clk);
        peak_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        settle();
        // R1 reset state
        chk("R1 filt", int'(peak_filt), 0);
        chk("R1 brownout", int'(brownout), 0);
        chk("R1 gate_en", int'(gate_en), 1);

        // R2/R3 table walk, no ticks
        for (int i = 0; i < 10; i++) begin
            pulse_peak(int'(VEC[i][19:10]));
            chk("R2/R3 table filt", int'(peak_filt), int'(VEC[i][9:0]));
        end
        // R4 hold without strobe
        repeat (20) @(negedge clk);
        chk("R4 hold", int'(peak_filt), 296);

        // R10: low value, many clocks, no ticks
        do_reset();
        pulse_peak(100);
        pulse_peak(90);
        pulse_peak(90);
        chk("R3 to low", int'(peak_filt), 90);
        repeat (300) @(negedge clk);
        chk("R10 no ticks no entry", int'(brownout), 0);

        // R5 entry after exactly DWELL ticks
        ticks(55);
        settle();
        chk("R5 before dwell", int'(brownout), 0);
        ticks(1);
        settle();
        chk("R5 entered", int'(brownout), 1);
        chk("R9 gate off", int'(gate_en), 0);

        // R7/R8 exit
        pulse_peak(120);
        ticks(55);
        settle();
        chk("R7 before dwell", int'(brownout), 1);
        pulse_peak(100);
        pulse_peak(100);
        chk("R7 at upper not high", int'(peak_filt), 110);
        ticks(30);
        settle();
        chk("R7 equal upper stays", int'(brownout), 1);
        pulse_peak(130);
        ticks(55);
        settle();
        chk("R8 timer cleared", int'(brownout), 1);
        ticks(1);
        settle();
        chk("R7 exited", int'(brownout), 0);
        chk("R9 gate on", int'(gate_en), 1);

        // R5 boundary and R6 clearing
        for (int i = 0; i < 7; i++) pulse_peak(0);
        chk("R3 slew to 95", int'(peak_filt), 95);
        ticks(60);
        settle();
        chk("R5 equal lower stays", int'(brownout), 0);
        pulse_peak(0);
        chk("R3 slew to 90", int'(peak_filt), 90);
        ticks(40);
        pulse_peak(200);
        chk("R2 jump up", int'(peak_filt), 200);
        for (int i = 0; i < 22; i++) pulse_peak(0);
        chk("R3 slew long", int'(peak_filt), 90);
        ticks(55);
        settle();
        chk("R6 timer cleared", int'(brownout), 0);
        ticks(1);
        settle();
        chk("R6 entered after full dwell", int'(brownout), 1);

        // R10 worst case from 128 V, 8 ticks per half cycle
        do_reset();
        pulse_peak(128);
        for (int i = 0; i < 7; i++) begin
            pulse_peak(0);
            ticks(8);
        end
        chk("R10 filt after 7 halves", int'(peak_filt), 93);
        ticks(47);
        settle();
        chk("R10 before 56 ticks", int'(brownout), 0);
        ticks(1);
        settle();
        chk("R10 entered at 56 ticks", int'(brownout), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule